// File: doc/BRIEF.md
# End-of-Interrupt Write Permission Gate

This block decides what happens when software writes the register that signals completion of a group-1 interrupt. For each write it looks at the current privilege level (0 to 3), which of the higher levels exist, whether level 3 runs in 32-bit state, and whether the processor sits in monitor mode. It also looks at the feature-present flags, the routing and trap controls held by levels 2 and 3, and the per-level enables for system-register access. From these it picks exactly one outcome: the access is undefined, it traps to level 2, it traps to level 3, it is redirected to the virtual copy of the register, or it is carried out. For the two trap outcomes it also gives a trap class code.

Each privilege level has its own chain of checks, and the order of each chain is fixed. The first check that matches decides the outcome. Level 1 has the longest chain, and the redirect to the virtual register sits at a fixed place in it: after both level-2 traps and before the level-3 routing check. The decision logic is combinational. The outcome is latched one clock after a request strobe, so the result is available as registered outputs. Updating the register and entering the exception are left to the logic around this block.

Top module: `eoi_access_gate`

## Requirements
- R1: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and `outcome` and `trap_class` then show the decision for the inputs that were sampled with that strobe. In a cycle after one with `req_valid` low, `out_valid` is 0 and `outcome` and `trap_class` keep their values.
- R2: While `rst` is high, `out_valid`, `outcome` and `trap_class` are all 0, and this holds after the first clock edge with reset high.
- R3: If `feat_lvl1_32` is 0 or `feat_intc` is 0, the outcome is undefined, whatever the other inputs are.
- R4: A write from privilege level 0 is always undefined.
- R5: At level 1 the first three checks run in this order. (a) Undefined if level-3 routing is active and `dbg_undef_prio` is 1. Level-3 routing is active when `l3_present` and `route_irq_l3` are both 1, unless `l3_is32` and `in_monitor` are both 1. (b) Otherwise, trap to level 2 if `l2_enabled` and `l2_grp_trap` are both 1. (c) Otherwise, undefined if `sysreg_en_l1` is 0.
- R6: At level 1, after the checks of R5: trap to level 2 if `l2_enabled` and `l2_grp1_trap_all` are both 1. Otherwise, redirect to the virtual register if `l2_enabled` and `l2_irq_redirect` are both 1. Nothing controlled by level 2 has any effect while `l2_enabled` is 0.
- R7: At level 1, after the checks of R6: if level-3 routing is active (as defined in R5), the outcome is undefined when `dbg_undef` is 1 and a trap to level 3 when it is 0. Otherwise the access is performed.
- R8: At level 2 the checks run in this order. (a) Undefined if `l3_present`, `route_irq_l3` and `dbg_undef_prio` are all 1. (b) Undefined if `sysreg_en_l2` is 0. (c) If `l3_present` and `route_irq_l3` are both 1, undefined when `dbg_undef` is 1 and a trap to level 3 otherwise. (d) Otherwise the access is performed. Monitor mode and the level-2 controls have no effect at this level.
- R9: At level 3 the outcome is undefined if `sysreg_en_l3` is 0 and performed otherwise. Routing and trap controls have no effect at this level.
- R10: `outcome` is one-hot whenever `out_valid` is 1. The bits are: bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 redirect to virtual, bit 4 perform.
- R11: When `out_valid` is 1, `trap_class` equals `TRAP_CLASS` (default 0x03) for either trap outcome and 0 for every other outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe: evaluate the write in this cycle |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| feat_lvl1_32 | input | 1 | Level 1 can run in 32-bit state |
| feat_intc | input | 1 | System-register interrupt controller interface present |
| l3_present | input | 1 | Level 3 exists |
| l3_is32 | input | 1 | Level 3 runs in 32-bit state |
| in_monitor | input | 1 | Processor is in monitor mode |
| route_irq_l3 | input | 1 | Physical IRQs are routed to level 3 |
| dbg_undef_prio | input | 1 | Secure-debug undefined condition that has priority over traps |
| dbg_undef | input | 1 | Secure-debug undefined condition that replaces the level-3 trap |
| l2_enabled | input | 1 | Level 2 is enabled in the current security state |
| l2_grp_trap | input | 1 | Level-2 trap for this system-register group |
| l2_grp1_trap_all | input | 1 | Level-2 trap of all group-1 interface accesses |
| l2_irq_redirect | input | 1 | Level-2 override that sends IRQ interface accesses to the virtual interface |
| sysreg_en_l1 | input | 1 | System-register access enable seen at level 1 |
| sysreg_en_l2 | input | 1 | System-register access enable seen at level 2 |
| sysreg_en_l3 | input | 1 | System-register access enable seen at level 3 |
| out_valid | output | 1 | Registered decision is valid |
| outcome | output | 5 | One-hot outcome: bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 virtual, bit 4 perform |
| trap_class | output | CLASS_W | Trap class code for trap outcomes, else 0 |

## Verification
Directed patterns enable two adjacent checks of one chain at the same time. Each result shows which check comes first: for example the group trap against a cleared level-1 enable, or the trap-all bit against the redirect. Further cases pair monitor mode with 32-bit level 3 at levels 1 and 2, to show that the monitor-mode exemption applies only at level 1. Other cases set the level-2 controls while `l2_enabled` is 0, or set the routing controls at level 3, to show that these controls have no effect there. A long run of random inputs over all four levels is then checked against a reference model that returns early at the first matching check. Strobe-free gaps between requests show that the registered outputs hold their values.

// File: rtl/eoi_gate_pkg.sv
`timescale 1ns/1ps
package eoi_gate_pkg;
  localparam int OUTC_N = 5;
  typedef logic [OUTC_N-1:0] oc_t;

  localparam oc_t OC_UNDEF = 5'b00001;
  localparam oc_t OC_TRAP2 = 5'b00010;
  localparam oc_t OC_TRAP3 = 5'b00100;
  localparam oc_t OC_VIRT  = 5'b01000;
  localparam oc_t OC_DO    = 5'b10000;
  localparam oc_t OC_TRAPS = OC_TRAP2 | OC_TRAP3;
endpackage

// File: rtl/eoi_lvl1_chain.sv
`timescale 1ns/1ps
module eoi_lvl1_chain
  import eoi_gate_pkg::*;
(
  input  logic l3_present,
  input  logic l3_is32,
  input  logic in_monitor,
  input  logic route_irq_l3,
  input  logic dbg_undef_prio,
  input  logic dbg_undef,
  input  logic l2_enabled,
  input  logic l2_grp_trap,
  input  logic l2_grp1_trap_all,
  input  logic l2_irq_redirect,
  input  logic sysreg_en,
  output oc_t  oc
);
  // A 32-bit level 3 does not claim routing while the core is in monitor mode.
  logic route_act;
  assign route_act = l3_present & route_irq_l3 & ~(l3_is32 & in_monitor);

  always_comb begin
    if (route_act && dbg_undef_prio)            oc = OC_UNDEF;
    else if (l2_enabled && l2_grp_trap)         oc = OC_TRAP2;
    else if (!sysreg_en)                        oc = OC_UNDEF;
    else if (l2_enabled && l2_grp1_trap_all)    oc = OC_TRAP2;
    else if (l2_enabled && l2_irq_redirect)     oc = OC_VIRT;
    else if (route_act)                         oc = dbg_undef ? OC_UNDEF : OC_TRAP3;
    else                                        oc = OC_DO;
  end
endmodule

// File: rtl/eoi_upper_chain.sv
`timescale 1ns/1ps
module eoi_upper_chain
  import eoi_gate_pkg::*;
(
  input  logic route_act,
  input  logic dbg_undef_prio,
  input  logic dbg_undef,
  input  logic sysreg_en,
  output oc_t  oc
);
  always_comb begin
    if (route_act && dbg_undef_prio) oc = OC_UNDEF;
    else if (!sysreg_en)             oc = OC_UNDEF;
    else if (route_act)              oc = dbg_undef ? OC_UNDEF : OC_TRAP3;
    else                             oc = OC_DO;
  end
endmodule

// File: rtl/eoi_outcome_reg.sv
`timescale 1ns/1ps
module eoi_outcome_reg
  import eoi_gate_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'(3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  oc_t                oc_next,
  output logic               valid_q,
  output oc_t                oc_q,
  output logic [CLASS_W-1:0] class_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      oc_q    <= '0;
      class_q <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        oc_q    <= oc_next;
        class_q <= ((oc_next & OC_TRAPS) != '0) ? TRAP_CLASS : '0;
      end
    end
  end

  assert_class_match_R11: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((class_q == TRAP_CLASS) == ((oc_q & OC_TRAPS) != '0)));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!valid_q && $stable(oc_q) && $stable(class_q)));

  assert_strobe_valid_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> valid_q);
endmodule

// File: rtl/eoi_access_gate.sv
`timescale 1ns/1ps
module eoi_access_gate
  import eoi_gate_pkg::*;
#(
  parameter int                 CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = CLASS_W'(3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         priv_lvl,
  input  logic               feat_lvl1_32,
  input  logic               feat_intc,
  input  logic               l3_present,
  input  logic               l3_is32,
  input  logic               in_monitor,
  input  logic               route_irq_l3,
  input  logic               dbg_undef_prio,
  input  logic               dbg_undef,
  input  logic               l2_enabled,
  input  logic               l2_grp_trap,
  input  logic               l2_grp1_trap_all,
  input  logic               l2_irq_redirect,
  input  logic               sysreg_en_l1,
  input  logic               sysreg_en_l2,
  input  logic               sysreg_en_l3,
  output logic               out_valid,
  output logic [OUTC_N-1:0]  outcome,
  output logic [CLASS_W-1:0] trap_class
);
  localparam int N_UPPER = 2;  // levels 2 and 3

  oc_t oc_l1;
  oc_t oc_up [N_UPPER];
  oc_t oc_sel;
  logic feat_ok;
  logic [N_UPPER-1:0] up_route;
  logic [N_UPPER-1:0] up_en;

  assign feat_ok     = feat_lvl1_32 & feat_intc;
  assign up_route[0] = l3_present & route_irq_l3;  // level 2: no monitor exemption
  assign up_route[1] = 1'b0;                       // level 3 owns the routing
  assign up_en       = {sysreg_en_l3, sysreg_en_l2};

  eoi_lvl1_chain u_lvl1 (
    .l3_present       (l3_present),
    .l3_is32          (l3_is32),
    .in_monitor       (in_monitor),
    .route_irq_l3     (route_irq_l3),
    .dbg_undef_prio   (dbg_undef_prio),
    .dbg_undef        (dbg_undef),
    .l2_enabled       (l2_enabled),
    .l2_grp_trap      (l2_grp_trap),
    .l2_grp1_trap_all (l2_grp1_trap_all),
    .l2_irq_redirect  (l2_irq_redirect),
    .sysreg_en        (sysreg_en_l1),
    .oc               (oc_l1)
  );

  for (genvar g = 0; g < N_UPPER; g++) begin : g_upper
    eoi_upper_chain u_chain (
      .route_act      (up_route[g]),
      .dbg_undef_prio (dbg_undef_prio),
      .dbg_undef      (dbg_undef),
      .sysreg_en      (up_en[g]),
      .oc             (oc_up[g])
    );
  end

  always_comb begin
    oc_sel = OC_UNDEF;
    if (feat_ok) begin
      unique case (priv_lvl)
        2'd1:    oc_sel = oc_l1;
        2'd2:    oc_sel = oc_up[0];
        2'd3:    oc_sel = oc_up[1];
        default: oc_sel = OC_UNDEF;
      endcase
    end
  end

  eoi_outcome_reg #(
    .CLASS_W    (CLASS_W),
    .TRAP_CLASS (TRAP_CLASS)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .oc_next   (oc_sel),
    .valid_q   (out_valid),
    .oc_q      (outcome),
    .class_q   (trap_class)
  );

  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(outcome) == 1));

  assert_feat_undef_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(feat_lvl1_32 && feat_intc)) |=> (outcome == OC_UNDEF));

  assert_lvl0_undef_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl == 2'd0) |=> (outcome == OC_UNDEF));

  assert_lvl3_no_trap_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv_lvl == 2'd3) |=> ((outcome & (OC_TRAPS | OC_VIRT)) == '0));
endmodule

// File: tb/tb_eoi_access_gate.sv
`timescale 1ns/1ps
module tb_eoi_access_gate;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] priv_lvl = 2'd0;
  logic feat_lvl1_32 = 1'b0, feat_intc = 1'b0, l3_present = 1'b0, l3_is32 = 1'b0;
  logic in_monitor = 1'b0, route_irq_l3 = 1'b0, dbg_undef_prio = 1'b0, dbg_undef = 1'b0;
  logic l2_enabled = 1'b0, l2_grp_trap = 1'b0, l2_grp1_trap_all = 1'b0, l2_irq_redirect = 1'b0;
  logic sysreg_en_l1 = 1'b0, sysreg_en_l2 = 1'b0, sysreg_en_l3 = 1'b0;
  logic out_valid;
  logic [4:0] outcome;
  logic [CW-1:0] trap_class;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  eoi_access_gate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .priv_lvl(priv_lvl),
    .feat_lvl1_32(feat_lvl1_32), .feat_intc(feat_intc), .l3_present(l3_present),
    .l3_is32(l3_is32), .in_monitor(in_monitor), .route_irq_l3(route_irq_l3),
    .dbg_undef_prio(dbg_undef_prio), .dbg_undef(dbg_undef), .l2_enabled(l2_enabled),
    .l2_grp_trap(l2_grp_trap), .l2_grp1_trap_all(l2_grp1_trap_all),
    .l2_irq_redirect(l2_irq_redirect), .sysreg_en_l1(sysreg_en_l1),
    .sysreg_en_l2(sysreg_en_l2), .sysreg_en_l3(sysreg_en_l3),
    .out_valid(out_valid), .outcome(outcome), .trap_class(trap_class)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference decision: returns the expected one-hot outcome and the requirement that decided it.
  function automatic int expect_outcome(output string tag);
    bit l1_route, up_route;
    l1_route = l3_present && route_irq_l3 && !(l3_is32 && in_monitor);
    up_route = l3_present && route_irq_l3;
    if (!feat_lvl1_32 || !feat_intc) begin tag = "R3"; return 1; end
    if (priv_lvl == 0) begin tag = "R4"; return 1; end
    if (priv_lvl == 3) begin tag = "R9"; return sysreg_en_l3 ? 16 : 1; end
    if (priv_lvl == 2) begin
      tag = "R8";
      if (up_route && dbg_undef_prio) return 1;
      if (!sysreg_en_l2) return 1;
      if (up_route) return dbg_undef ? 1 : 4;
      return 16;
    end
    tag = "R5";
    if (l1_route && dbg_undef_prio) return 1;
    if (l2_enabled && l2_grp_trap) return 2;
    if (!sysreg_en_l1) return 1;
    tag = "R6";
    if (l2_enabled && l2_grp1_trap_all) return 2;
    if (l2_enabled && l2_irq_redirect) return 8;
    tag = "R7";
    if (l1_route) return dbg_undef ? 1 : 4;
    return 16;
  endfunction

  task automatic base(input int lvl);
    priv_lvl = 2'(lvl);
    feat_lvl1_32 = 1; feat_intc = 1; l3_present = 0; l3_is32 = 0; in_monitor = 0;
    route_irq_l3 = 0; dbg_undef_prio = 0; dbg_undef = 0; l2_enabled = 0;
    l2_grp_trap = 0; l2_grp1_trap_all = 0; l2_irq_redirect = 0;
    sysreg_en_l1 = 1; sysreg_en_l2 = 1; sysreg_en_l3 = 1;
  endtask

  // Inputs are already set (before a negedge); strobe one cycle, check after the edge.
  task automatic apply(input bit with_gap);
    string tag;
    int exp_oc, exp_cls;
    logic [4:0] held_oc;
    logic [CW-1:0] held_cls;
    exp_oc = expect_outcome(tag);
    exp_cls = (exp_oc == 2 || exp_oc == 4) ? 3 : 0;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(out_valid === 1'b1, "R1 valid", int'(out_valid), 1);
    check(outcome === 5'(exp_oc), tag, int'(outcome), exp_oc);
    check($countones(outcome) == 1, "R10 onehot", int'(outcome), exp_oc);
    check(trap_class === CW'(exp_cls), "R11 class", int'(trap_class), exp_cls);
    if (with_gap) begin
      held_oc = outcome; held_cls = trap_class;
      @(negedge clk);
      check(out_valid === 1'b0, "R1 idle valid", int'(out_valid), 0);
      check(outcome === held_oc && trap_class === held_cls, "R1 hold",
            int'({trap_class, outcome}), int'({held_cls, held_oc}));
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && outcome === 5'd0 && trap_class === '0, "R2 reset",
          int'({trap_class, outcome, out_valid}), 0);
    rst = 0;
    @(negedge clk);
    check(out_valid === 1'b0, "R2 after reset", int'(out_valid), 0);

    // R3: features absent
    base(3); feat_intc = 0; apply(1);
    base(1); feat_lvl1_32 = 0; apply(0);
    // R4: level 0 with everything permissive
    base(0); apply(1);
    // R5 ordering
    base(1); l3_present = 1; route_irq_l3 = 1; dbg_undef_prio = 1; l2_enabled = 1; l2_grp_trap = 1; apply(0);
    base(1); l2_enabled = 1; l2_grp_trap = 1; sysreg_en_l1 = 0; apply(0);
    base(1); sysreg_en_l1 = 0; l2_enabled = 1; l2_grp1_trap_all = 1; apply(0);
    // R6 ordering and level-2 gating
    base(1); l2_enabled = 1; l2_grp1_trap_all = 1; l2_irq_redirect = 1; apply(1);
    base(1); l2_enabled = 1; l2_irq_redirect = 1; l3_present = 1; route_irq_l3 = 1; apply(0);
    base(1); l2_irq_redirect = 1; l2_grp_trap = 1; l2_grp1_trap_all = 1; apply(0);
    // R7 routing and monitor exemption at level 1
    base(1); l3_present = 1; route_irq_l3 = 1; apply(0);
    base(1); l3_present = 1; route_irq_l3 = 1; dbg_undef = 1; apply(0);
    base(1); l3_present = 1; route_irq_l3 = 1; l3_is32 = 1; in_monitor = 1; dbg_undef_prio = 1; apply(0);
    base(1); route_irq_l3 = 1; apply(0);
    // R8 level 2
    base(2); l3_present = 1; route_irq_l3 = 1; dbg_undef_prio = 1; apply(0);
    base(2); sysreg_en_l2 = 0; apply(0);
    base(2); l3_present = 1; route_irq_l3 = 1; l3_is32 = 1; in_monitor = 1; apply(0);
    base(2); l3_present = 1; route_irq_l3 = 1; dbg_undef = 1; apply(0);
    base(2); l2_enabled = 1; l2_grp_trap = 1; l2_irq_redirect = 1; sysreg_en_l1 = 0; apply(1);
    // R9 level 3
    base(3); sysreg_en_l3 = 0; apply(0);
    base(3); l3_present = 1; route_irq_l3 = 1; dbg_undef_prio = 1; l2_enabled = 1; l2_grp_trap = 1; apply(1);

    // Random sweep against the reference
    for (int i = 0; i < 3000; i++) begin
      logic [17:0] r;
      r = 18'($urandom);
      priv_lvl = r[1:0];
      feat_lvl1_32 = ($urandom_range(0, 15) != 0);
      feat_intc = ($urandom_range(0, 15) != 0);
      l3_present = r[2]; l3_is32 = r[3]; in_monitor = r[4]; route_irq_l3 = r[5];
      dbg_undef_prio = r[6] & r[7]; dbg_undef = r[8]; l2_enabled = r[9];
      l2_grp_trap = r[10] & r[11]; l2_grp1_trap_all = r[12] & r[13];
      l2_irq_redirect = r[14]; sysreg_en_l1 = r[15] | r[2]; sysreg_en_l2 = r[16] | r[3];
      sysreg_en_l3 = r[17] | r[4];
      apply(r[0] & r[9]);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule